// File: doc/BRIEF.md
# Serial Two-Wire Register Bank Slave

This block is an I2C slave that gives a host controller access to a bank of 8-bit control registers and a handful of read-only status locations. The bus lines are oversampled by the system clock; start and stop conditions and SCL edges are found from the synchronized samples. The slave drives SDA only by pulling it low, through an output enable that the pad turns into an open-drain driver.

A host writes by sending the device address with the write bit, a one-byte register pointer, and then any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances by one. To read, the host first sets the pointer in a write transfer. It then issues a repeated start with the read bit and clocks out bytes, acknowledging each byte it wants to be followed by another. Writes land only in the low control window. Reads return live status values only at four addresses; every other address reads as zero. Out-of-window writes are acknowledged like any other byte, so the host sees no bus error.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {1101b, addr_sel, 11b}. This gives write address D6h when addr_sel is 0 and DEh when addr_sel is 1. Any other address gets no acknowledge, and the transfer is ignored until the next start.
- R2: In a write transfer, the slave pulls SDA low in the acknowledge slot after the address, after the pointer byte, and after every data byte.
- R3: Each data byte of a write goes to the register at the pointer, and the pointer then advances by one. Register n appears on regs_o[8n+7:8n].
- R4: A data byte whose pointer is above 21h is acknowledged but changes no register. Pointers 00h to 21h are writable.
- R5: After a repeated start with the read bit set, the slave sends the byte at the pointer MSB first and advances the pointer after each byte. It returns stat_i[7:0] at 28h, stat_i[15:8] at 2Ah, stat_i[23:16] at 2Bh and stat_i[31:24] at 2Ch.
- R6: A read at any pointer other than 28h and 2Ah to 2Ch returns 00h. This includes the writable registers.
- R7: After reset, register 00h holds 80h, register 12h holds 0Fh, every other register holds 00h, and SDA is released.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and waits for a new start. A stop condition always returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Strap that sets one bit of the device address |
| stat_i | input | 32 | Four status bytes offered for reading |
| sda_oe | output | 1 | 1 pulls SDA low |
| regs_o | output | 272 | Contents of the 34 control registers |

## Verification
The bench builds the block with its default parameters: 34 registers, writable window ending at 21h, and status at 28h and 2Ah to 2Ch. With these values, random pointers between 00h and 3Fh fall on both sides of the write limit and cover the status holes at 29h and beyond 2Ch. Short bursts of up to four bytes cross the 21h/22h boundary and the 28h to 2Ch status run in both directions. Directed transfers also toggle the address strap, end a read with a host NACK, and write at the last writable pointer.

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int NREG = 34,
  parameter int NSTAT = 4,
  parameter logic [3:0] DEV_HI = 4'b1101,
  parameter logic [1:0] DEV_LO = 2'b11,
  parameter logic [7:0] WR_LAST = 8'h21,
  parameter logic [7:0] RD_SOLO = 8'h28,
  parameter logic [7:0] RD_BASE = 8'h2A,
  parameter logic [8*NREG-1:0] RST_VAL =
    (8*NREG)'(8'h80) | ((8*NREG)'(8'h0F) << (8*18))
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 addr_sel,
  input  logic [8*NSTAT-1:0]   stat_i,
  output logic                 sda_oe,
  output logic [8*NREG-1:0]    regs_o
);
  localparam int IW = $clog2(NREG);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_SUB, P_DATA} ph_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  ph_t        ph;
  logic [3:0] cnt;
  logic [7:0] sh, ptr, rd_byte;
  logic       go_tx, mack;
  logic [7:0] rf [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire sda_s     = sda_q[1];
  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire addr_hit  = sh[7:1] == {DEV_HI, addr_sel, DEV_LO};
  wire wr_ok     = (ptr <= WR_LAST) && (ptr < 8'(NREG));

  always_comb begin
    rd_byte = 8'h00;
    if (ptr == RD_SOLO) rd_byte = stat_i[7:0];
    for (int k = 1; k < NSTAT; k++)
      if (ptr == RD_BASE + 8'(k - 1)) rd_byte = stat_i[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= P_ADDR;
      cnt <= '0;
      sh <= '0;
      ptr <= '0;
      go_tx <= 1'b0;
      mack <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= RST_VAL[8*i +: 8];
    end else if (start_det) begin
      st <= S_RX;
      ph <= P_ADDR;
      cnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            case (ph)
              P_ADDR:
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  st <= S_ACK;
                  go_tx <= sh[0];
                  ph <= P_SUB;
                end else st <= S_IDLE;
              P_SUB: begin
                ptr <= sh;
                sda_oe <= 1'b1;
                st <= S_ACK;
                go_tx <= 1'b0;
                ph <= P_DATA;
              end
              default: begin
                if (wr_ok) rf[ptr[IW-1:0]] <= sh;
                ptr <= ptr + 8'd1;
                sda_oe <= 1'b1;
                st <= S_ACK;
                go_tx <= 1'b0;
              end
            endcase
          end
        S_ACK:
          if (scl_fall) begin
            if (go_tx) begin
              sh <= rd_byte;
              ptr <= ptr + 8'd1;
              sda_oe <= ~rd_byte[7];
              st <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st <= S_RX;
            end
          end
        S_TX:
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              st <= S_MACK;
            end else begin
              sh <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
        S_MACK:
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              sh <= rd_byte;
              ptr <= ptr + 8'd1;
              sda_oe <= ~rd_byte[7];
              st <= S_TX;
            end else st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_out
    assign regs_o[8*gi +: 8] = rf[gi];
  end
endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk #(
  parameter int NREG = 34,
  parameter logic [7:0] WR_LAST = 8'h21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              stop_det,
  input logic [7:0]        ptr,
  input logic [8*NREG-1:0] regs_o
);
  a_r2_drive_when_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r8_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r4_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $past(ptr) <= WR_LAST);

  a_r3_ptr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> ptr == $past(ptr) + 8'd1);
endmodule

bind i2c_regbank_slave i2c_regbank_chk #(.NREG(NREG), .WR_LAST(WR_LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_q[1]), .sda_oe(sda_oe),
  .stop_det(stop_det), .ptr(ptr), .regs_o(regs_o));

// File: tb/sim_i2c_regbank_slave.sv
`timescale 1ns/1ps
module sim_i2c_regbank_slave;
  localparam int NREG = 34;
  localparam int Q = 100;

  logic clk = 0, rst_n = 0, scl = 1, mlow = 0, strap = 1;
  logic [31:0] stat;
  logic sda_oe;
  logic [8*NREG-1:0] regs_o;
  wire sda = ~(mlow | sda_oe);

  i2c_regbank_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .addr_sel(strap), .stat_i(stat), .sda_oe(sda_oe), .regs_o(regs_o));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] mdl [NREG];

  initial begin
    #1_900_000;
    nchk++; nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    int bad = -1;
    nchk++;
    for (int i = NREG - 1; i >= 0; i--) if (regs_o[8*i +: 8] !== mdl[i]) bad = i;
    if (bad >= 0) begin
      nfail++;
      $display("FAIL %s: reg %0d actual %h expected %h", tag, bad, regs_o[8*bad +: 8], mdl[bad]);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      8'h28: return stat[7:0];
      8'h2A: return stat[15:8];
      8'h2B: return stat[23:16];
      8'h2C: return stat[31:24];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] dev(logic s, logic rd);
    return {4'b1101, s, 2'b11, rd};
  endfunction

  task automatic i_start();
    mlow = 0; #Q; scl = 1; #Q; mlow = 1; #Q; scl = 0; #Q;
  endtask

  task automatic i_stop();
    mlow = 1; #Q; scl = 1; #Q; mlow = 0; #(2*Q);
  endtask

  task automatic i_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mlow = ~b[i]; #Q; scl = 1; #(2*Q); scl = 0; #Q;
    end
    mlow = 0; #Q; scl = 1; #Q; ack = ~sda; #Q; scl = 0; #Q;
  endtask

  task automatic i_rbyte(output logic [7:0] b, input logic ack);
    mlow = 0;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl = 1; #Q; b[i] = sda; #Q; scl = 0;
    end
    mlow = ack; #Q; scl = 1; #(2*Q); scl = 0; #Q; mlow = 0;
  endtask

  task automatic do_write(logic [7:0] sub, int n, string tag);
    logic a;
    logic [7:0] d;
    i_start();
    i_wbyte(dev(strap, 0), a); chk({tag, " R2 addr ack"}, a, 1);
    i_wbyte(sub, a); chk({tag, " R2 sub ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      i_wbyte(d, a); chk({tag, " R2/R4 data ack"}, a, 1);
      if (sub <= 8'h21) mdl[sub] = d;
      sub++;
    end
    i_stop();
    chk_regs({tag, " R3/R4 regs"});
  endtask

  task automatic do_read(logic [7:0] sub, int n, string tag);
    logic a;
    logic [7:0] d;
    i_start();
    i_wbyte(dev(strap, 0), a); chk({tag, " R2 addr ack"}, a, 1);
    i_wbyte(sub, a); chk({tag, " R2 sub ack"}, a, 1);
    i_start();
    i_wbyte(dev(strap, 1), a); chk({tag, " R1 read addr ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      i_rbyte(d, k != n - 1);
      chk({tag, " R5/R6 read data"}, d, exp_rd(sub));
      sub++;
    end
    chk({tag, " R8 released after nack"}, sda_oe, 0);
    i_stop();
  endtask

  initial begin
    logic a;
    void'($urandom(32'd1234));
    stat = $urandom;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    mdl[0] = 8'h80; mdl[18] = 8'h0F;
    #3; #200; rst_n = 1; #Q;
    chk_regs("R7 reset values");
    chk("R7 sda released", sda_oe, 0);

    do_write(8'h00, 3, "burst at 00h");
    do_write(8'h20, 3, "R4 limit crossing");
    do_write(8'h30, 1, "R4 above window");
    do_read(8'h28, 5, "status run");
    do_read(8'h00, 2, "R6 writable reads zero");
    do_read(8'h2C, 2, "R6 past status");

    i_start();
    i_wbyte(dev(0, 0), a); chk("R1 wrong strap nack", a, 0);
    i_wbyte(8'h05, a);
    i_wbyte(8'hEE, a);
    i_stop();
    chk_regs("R1 ignored transfer");
    strap = 0;
    do_write(8'h05, 1, "R1 strap low D6h");
    strap = 1;

    for (int t = 0; t < 16; t++) begin
      do_write(8'($urandom_range(0, 63)), $urandom_range(1, 4), "rand write");
      stat = $urandom;
      do_read(8'($urandom_range(38, 47)), $urandom_range(1, 4), "rand read");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule